// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block drives a small number of pulse-width-modulated pins, four by default, from one clock. Software programs each channel through a plain 32-bit register port with two counts: the length of a full cycle in clock ticks, and how many of those ticks are spent at the low level. A cycle always begins with its low part and finishes with its high part. Four shared control words each hold one bit per channel: run, invert, apply-new-values and pin-enable. A fifth shared word reports which channels have been stopped.

Starting a channel copies its two counts into private working copies, and the counter runs from those copies only. Later writes to the programming registers stay parked until software pulses the channel's apply bit to 1 and then back to 0. The parked values then take over at the next cycle boundary, so the cycle in progress is never cut short. A stopped channel always drives its pin low.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every period register reads 2, every low-phase register reads 1, the polarity, start, done, update and output-enable words read 0, and every pin is low.
- R2: Register addresses: the low-phase count of channel n is at 8·n, its period at 8·n+4. Polarity is at 0x40, start at 0x44, done at 0x48 (read only), update at 0x4C and output enable at 0xD0. Bit n of each shared word belongs to channel n. Written values read back.
- R3: A period write stores bits [29:0] of the data. Any stored value below 2 is replaced by 2.
- R4: A running channel with period P and low count L drives L low cycles and then P−L high cycles, repeating. P=2, L=1 gives alternating single cycles.
- R5: A low count of 0 holds the pin high continuously while the channel runs.
- R6: Setting polarity bit n inverts channel n, giving L high cycles and P−L low cycles.
- R7: A 0-to-1 change of start bit n latches the channel's period and low count. Writes to those registers while the channel runs do not change its waveform.
- R8: After update bit n is written 1 and then 0, the channel's current register values take effect at the next period boundary.
- R9: A channel whose start bit is 0 drives its pin low, whatever its polarity bit.
- R10: A pin whose output-enable bit is 0 is held low.
- R11: Clearing start bit n sets done bit n. Setting start bit n clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per word |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NUM_CH | One PWM pin per channel |

## Verification
The bench builds the block with its default parameters: four channels, 30-bit counts and an unregistered pin. With four channels, every bit of the shared words is used, and a different waveform can run on each channel at once: the fastest 1/1 toggle, a full-high channel and an inverted channel. The 30-bit count width lets the bench confirm the top of the period range by reading back an all-ones write. Short periods keep each high/low measurement within a few dozen cycles.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   localparam int unsigned REG_ADDR_W = 8;
   localparam int unsigned CH_STRIDE  = 8;
   localparam int unsigned PER_OFFSET = 4;
   localparam logic [REG_ADDR_W-1:0] ADR_POL   = 8'h40;
   localparam logic [REG_ADDR_W-1:0] ADR_START = 8'h44;
   localparam logic [REG_ADDR_W-1:0] ADR_DONE  = 8'h48;
   localparam logic [REG_ADDR_W-1:0] ADR_UPD   = 8'h4C;
   localparam logic [REG_ADDR_W-1:0] ADR_OE    = 8'hD0;
   localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 30
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  logic [REG_ADDR_W-1:0]            addr,
   input  logic [31:0]                      wdata,
   output logic [31:0]                      rdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]     per_r,
   output logic [NUM_CH-1:0][CNT_W-1:0]     low_r,
   output logic [NUM_CH-1:0]                pol_r,
   output logic [NUM_CH-1:0]                start_r,
   output logic [NUM_CH-1:0]                done_r,
   output logic [NUM_CH-1:0]                upd_r,
   output logic [NUM_CH-1:0]                oe_r
);
   localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PERIOD);

   logic [CNT_W-1:0]  wcnt;
   logic [NUM_CH-1:0] wbits;
   assign wcnt  = wdata[CNT_W-1:0];
   assign wbits = wdata[NUM_CH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) begin
            per_r[i] <= PER_FLOOR;
            low_r[i] <= CNT_W'(1);
         end
         pol_r   <= '0;
         start_r <= '0;
         done_r  <= '0;
         upd_r   <= '0;
         oe_r    <= '0;
      end else if (wr) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == REG_ADDR_W'(i * CH_STRIDE))
               low_r[i] <= wcnt;
            if (addr == REG_ADDR_W'(i * CH_STRIDE + PER_OFFSET))
               per_r[i] <= (wcnt < PER_FLOOR) ? PER_FLOOR : wcnt;
         end
         case (addr)
            ADR_POL:   pol_r <= wbits;
            ADR_UPD:   upd_r <= wbits;
            ADR_OE:    oe_r  <= wbits;
            ADR_START: begin
               start_r <= wbits;
               done_r  <= (done_r | (start_r & ~wbits)) & ~wbits;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == REG_ADDR_W'(i * CH_STRIDE))
            rdata = 32'(low_r[i]);
         if (addr == REG_ADDR_W'(i * CH_STRIDE + PER_OFFSET))
            rdata = 32'(per_r[i]);
      end
      case (addr)
         ADR_POL:   rdata = 32'(pol_r);
         ADR_START: rdata = 32'(start_r);
         ADR_DONE:  rdata = 32'(done_r);
         ADR_UPD:   rdata = 32'(upd_r);
         ADR_OE:    rdata = 32'(oe_r);
         default: ;
      endcase
   end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
   parameter int unsigned CNT_W   = 30,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             upd,
   input  logic             pol,
   input  logic             oe,
   input  logic [CNT_W-1:0] per_in,
   input  logic [CNT_W-1:0] low_in,
   output logic             pin
);
   logic             start_q, upd_q, run, pend;
   logic [CNT_W-1:0] cnt, wper, wlow, pper, plow;
   logic             start_rise, upd_fall, at_end, level;

   assign start_rise = start & ~start_q;
   assign upd_fall   = upd_q & ~upd;
   assign at_end     = (cnt == wper - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         upd_q   <= 1'b0;
         run     <= 1'b0;
         pend    <= 1'b0;
         cnt     <= '0;
         wper    <= '0;
         wlow    <= '0;
         pper    <= '0;
         plow    <= '0;
      end else begin
         start_q <= start;
         upd_q   <= upd;
         if (!start) begin
            run  <= 1'b0;
            pend <= 1'b0;
            cnt  <= '0;
         end else if (start_rise) begin
            run  <= 1'b1;
            pend <= 1'b0;
            cnt  <= '0;
            wper <= per_in;
            wlow <= low_in;
         end else if (run) begin
            if (at_end) begin
               cnt <= '0;
               if (pend) begin
                  wper <= pper;
                  wlow <= plow;
                  pend <= 1'b0;
               end
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
            if (upd_fall) begin
               pend <= 1'b1;
               pper <= per_in;
               plow <= low_in;
            end
         end
      end
   end

   assign level = run & oe & (pol ^ (cnt >= wlow));

   generate
      if (OUT_REG) begin : g_reg_out
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= level;
         end
         assign pin = pin_q;
      end else begin : g_comb_out
         assign pin = level;
      end
   endgenerate
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned CNT_W   = 30,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("pwm_bank: NUM_CH must be 1..8 to fit below the shared words");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("pwm_bank: CNT_W must be 2..32");
      end
   endgenerate

   logic [NUM_CH-1:0][CNT_W-1:0] per_r, low_r;
   logic [NUM_CH-1:0]            pol_r, start_r, done_r, upd_r, oe_r;

   pwm_bank_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .per_r   (per_r),
      .low_r   (low_r),
      .pol_r   (pol_r),
      .start_r (start_r),
      .done_r  (done_r),
      .upd_r   (upd_r),
      .oe_r    (oe_r)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pwm_bank_chan #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start_r[c]),
            .upd    (upd_r[c]),
            .pol    (pol_r[c]),
            .oe     (oe_r[c]),
            .per_in (per_r[c]),
            .low_in (low_r[c]),
            .pin    (pwm_out[c])
         );
      end
   endgenerate
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 30
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         reg_wr,
   input logic [7:0]                   reg_addr,
   input logic [31:0]                  reg_wdata,
   input logic [NUM_CH-1:0][CNT_W-1:0] per_r,
   input logic [NUM_CH-1:0]            pol_r,
   input logic [NUM_CH-1:0]            start_r,
   input logic [NUM_CH-1:0]            done_r,
   input logic [NUM_CH-1:0]            pwm_out
);
   AST_POL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_POL) |=> (pol_r == $past(reg_wdata[NUM_CH-1:0]))); // R2

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
         AST_PER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            per_r[i] >= CNT_W'(MIN_PERIOD)); // R3
         AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!start_r[i] && !$past(start_r[i]) && !$past(start_r[i], 2)) |-> !pwm_out[i]); // R9
         AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(start_r[i]) |-> done_r[i]); // R11
         AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(start_r[i]) |-> !done_r[i]); // R11
      end
   endgenerate
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .per_r     (per_r),
   .pol_r     (pol_r),
   .start_r   (start_r),
   .done_r    (done_r),
   .pwm_out   (pwm_out)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  pwm_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   pwm_bank dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
   );

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cycles);
         summary();
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // Sync on a rising pin, then count one high phase and one low phase.
   task automatic meas(input int ch, output int hi, output int lo);
      int guard = 0;
      hi = 0; lo = 0;
      do begin @(negedge clk); guard++; end while (pwm_out[ch] !== 1'b0 && guard < 2000);
      do begin @(negedge clk); guard++; end while (pwm_out[ch] !== 1'b1 && guard < 4000);
      while (pwm_out[ch] === 1'b1 && hi < 4000) begin hi++; @(negedge clk); end
      while (pwm_out[ch] === 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
   endtask

   task automatic steady(input int ch, input logic v, input int n, input string tag);
      int bad = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch] !== v) bad++;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h04, d); chk(d == 2, "R1 period reset", d, 2);
      rd(8'h18, d); chk(d == 1, "R1 low reset ch3", d, 1);
      rd(8'h44, d); chk(d == 0, "R1 start reset", d, 0);
      rd(8'hD0, d); chk(d == 0, "R1 oe reset", d, 0);
      chk(pwm_out == 4'b0, "R1 pins low", pwm_out, 0);
   endtask

   task automatic t_map_clamp();
      logic [31:0] d;
      wr(8'h0C, 32'd1);          rd(8'h0C, d); chk(d == 2, "R3 period floor", d, 2);
      wr(8'h0C, 32'hFFFF_FFFF);  rd(8'h0C, d); chk(d == 32'h3FFF_FFFF, "R3 period 30 bits", d, 32'h3FFF_FFFF);
      wr(8'h0C, 32'd2);
      wr(8'h4C, 32'h5);          rd(8'h4C, d); chk(d == 5, "R2 update word", d, 5);
      wr(8'h4C, 32'h0);
   endtask

   task automatic t_wave();
      int hi, lo;
      wr(8'h00, 3);  wr(8'h04, 10);
      wr(8'h08, 1);  wr(8'h0C, 2);
      wr(8'h10, 0);  wr(8'h14, 6);
      wr(8'h18, 5);  wr(8'h1C, 8);
      wr(8'h40, 32'h8); wr(8'hD0, 32'hF); wr(8'h44, 32'hF);
      meas(0, hi, lo); chk(hi == 7, "R4 ch0 high", hi, 7); chk(lo == 3, "R4 ch0 low", lo, 3);
      meas(1, hi, lo); chk(hi == 1 && lo == 1, "R4 fastest ch1", hi * 10 + lo, 11);
      steady(2, 1'b1, 30, "R5 full duty ch2");
      meas(3, hi, lo); chk(hi == 5, "R6 inverted high", hi, 5); chk(lo == 3, "R6 inverted low", lo, 3);
   endtask

   task automatic t_hold_update();
      int hi, lo;
      logic [31:0] d;
      wr(8'h00, 10); wr(8'h04, 20);
      rd(8'h04, d); chk(d == 20, "R2 period readback", d, 20);
      meas(0, hi, lo); chk(hi == 7 && lo == 3, "R7 running write ignored", hi * 100 + lo, 703);
      wr(8'h4C, 32'h1); wr(8'h4C, 32'h0);
      repeat (25) @(negedge clk);
      meas(0, hi, lo); chk(hi == 10 && lo == 10, "R8 update applied", hi * 100 + lo, 1010);
   endtask

   task automatic t_oe();
      wr(8'hD0, 32'hE);
      repeat (2) @(negedge clk);
      steady(0, 1'b0, 45, "R10 oe gates pin");
      wr(8'hD0, 32'hF);
   endtask

   task automatic t_stop_restart();
      int hi, lo;
      logic [31:0] d;
      wr(8'h44, 32'hE);
      repeat (2) @(negedge clk);
      steady(0, 1'b0, 30, "R9 stopped pin low");
      rd(8'h48, d); chk(d[0] == 1'b1, "R11 done set", d[0], 1);
      wr(8'h00, 2); wr(8'h04, 5);
      wr(8'h44, 32'hF);
      rd(8'h48, d); chk(d[0] == 1'b0, "R11 done cleared", d[0], 0);
      meas(0, hi, lo); chk(hi == 3 && lo == 2, "R7 start latches", hi * 10 + lo, 32);
      wr(8'h44, 32'h7);
      repeat (2) @(negedge clk);
      steady(3, 1'b0, 20, "R9 inverted idle low");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map_clamp();
      t_wave();
      t_hold_update();
      t_oe();
      t_stop_restart();
      summary();
   end
endmodule